// File: doc/BRIEF.md
# Signed Arithmetic Shift Unit

This unit performs a signed arithmetic shift of one 16-bit word, or of a 32-bit value held as a high and a low word. The caller supplies the operand, a 6-bit two's-complement shift count and a mode bit, then pulses `start`. One clock later the unit returns the shifted value together with negative, zero, overflow and carry flags, and raises `done` for a single cycle.

A positive count shifts left and a negative count shifts right. Right shifts copy the sign bit into the vacated positions. The carry flag holds the last bit that left the operand. On a left shift, the overflow flag reports that the value changed sign or lost significant bits. Fetching the count and writing the destination registers are the job of the surrounding datapath.

Top module: `arith_shifter`

## Requirements
- R1: Only the 6 count bits are used, read as two's complement. Values 1..31 shift left by that amount. Values 32..63 shift right by 64 minus the value, so 63 is a right shift by 1 and 32 is a right shift by 32.
- R2: A count of 0 returns the operand unchanged, with carry and overflow both 0.
- R3: A left shift fills with zeros from the bottom. Carry equals the last bit shifted out of the top of the operand.
- R4: On a left shift, overflow is 1 exactly when some bit that left the top of the operand differs from the sign bit of the result.
- R5: In single mode, left counts 16..31 give a zero result. Carry equals operand bit 0 for count 16 and 0 for larger counts. Overflow is 1 exactly when the operand was nonzero.
- R6: A right shift fills with the operand's sign bit, sets carry to the last bit shifted out of the bottom, and clears overflow. Count 32 gives all ones for a negative operand and zero otherwise, with carry equal to the operand sign.
- R7: In double mode (`dbl_mode`=1) the operand is {`opnd_hi`,`opnd_lo`}. `res_hi` carries result bits 31:16 and `res_lo` carries bits 15:0. Negative and zero are taken from the full 32-bit result.
- R8: In single mode (`dbl_mode`=0) the operand is `opnd_lo` and `opnd_hi` is ignored. The result appears on `res_lo` and `res_hi` reads 0. Negative and zero are taken from the 16-bit result.
- R9: Inputs are sampled on a clock edge with `start`=1. Results and flags appear after that edge and `done` is 1 for exactly that one cycle. Without `start`, the outputs hold their values.
- R10: After a synchronous active-low reset, all results and flags read 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Sample the inputs and perform a shift |
| dbl_mode | input | 1 | 1: 32-bit pair, 0: single 16-bit word |
| opnd_hi | input | 16 | High word of the operand (double mode only) |
| opnd_lo | input | 16 | Low word of the operand, or the single-mode operand |
| count | input | 6 | Signed shift count, -32..31 |
| res_hi | output | 16 | Result high word (0 in single mode) |
| res_lo | output | 16 | Result low word |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Left-shift overflow |
| flag_c | output | 1 | Last bit shifted out |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all 64 count codes in both modes over fixed edge patterns and random operands. It compares each result against a bit-serial model that shifts one place at a time.

Each corner case has a characteristic failure:
- Count 0: a design that treats zero as a left shift would report the sign bit as carry.
- Count 32: a design that decodes the count as unsigned would shift left instead of filling with the sign.
- Single-mode counts of 16 and above: a design that drops the upper shifted-out bits would miss overflow for operands whose set bits lie only in the low half.
- Negative operands: a design that fills a right shift with zeros, or takes carry one place off, would disagree with the model.

// File: rtl/ash_pkg.sv
// Package: shared widths and the flag bundle of the arithmetic shift unit.
// Assumes the count width fixes the widest shift span (2**CNT_W bits).
package ash_pkg;
    localparam int ASH_WORD_W = 16;
    localparam int ASH_CNT_W  = 6;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ash_flags_t;
endpackage

// File: rtl/ash_count_decode.sv
// Module: turns the two's-complement shift count into direction and magnitude.
// Assumes the count is CNT_W bits; the magnitude is 1..2**(CNT_W-1) when nonzero.
module ash_count_decode #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_right,
    output logic [CNT_W-1:0] amount
);
    // Split count into sign and absolute value.
    always_comb begin
        is_zero  = (count == '0);
        is_right = count[CNT_W-1];
        amount   = is_right ? (CNT_W'(0) - count) : count;
    end
endmodule

// File: rtl/ash_lane.sv
// Module: arithmetic shift of one LANE_W-bit operand and its flags.
// Assumes EXT_W >= LANE_W + 2**(CNT_W-1), so every bit shifted out is kept for overflow.
module ash_lane
    import ash_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int CNT_W  = 6,
    parameter int EXT_W  = 64
) (
    input  logic [LANE_W-1:0] opnd,
    input  logic              is_zero,
    input  logic              is_right,
    input  logic [CNT_W-1:0]  amount,
    output logic [LANE_W-1:0] res,
    output ash_flags_t        flags
);
    localparam int FILL_W = EXT_W - LANE_W;

    logic signed [EXT_W-1:0] ext;
    logic        [EXT_W-1:0] left;

    // Sign-extend the operand to the working width and form the left shift.
    always_comb begin
        ext  = {{FILL_W{opnd[LANE_W-1]}}, opnd};
        left = ext << amount;
    end

    // Choose the result and derive carry and overflow for the direction.
    always_comb begin
        if (is_zero) begin
            res     = opnd;
            flags.c = 1'b0;
            flags.v = 1'b0;
        end else if (is_right) begin
            res     = LANE_W'(ext >>> amount);
            flags.c = ext[amount - CNT_W'(1)];
            flags.v = 1'b0;
        end else begin
            res     = left[LANE_W-1:0];
            flags.c = left[LANE_W];
            flags.v = (left[EXT_W-1:LANE_W] != {FILL_W{left[LANE_W-1]}});
        end
        flags.n = res[LANE_W-1];
        flags.z = (res == '0);
    end
endmodule

// File: rtl/arith_shifter.sv
// Module: registered signed arithmetic shifter with single and double word modes.
// Assumes start is a one-cycle strobe; results hold until the next start.
module arith_shifter
    import ash_pkg::*;
#(
    parameter int WORD_W = ASH_WORD_W,
    parameter int CNT_W  = ASH_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dbl_mode,
    input  logic [WORD_W-1:0] opnd_hi,
    input  logic [WORD_W-1:0] opnd_lo,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              done
);
    localparam int DBL_W  = 2 * WORD_W;
    localparam int EXT_W  = 2 ** CNT_W;
    localparam int NLANES = 2;

    logic              is_zero;
    logic              is_right;
    logic [CNT_W-1:0]  amount;
    logic [DBL_W-1:0]  opnd_full;
    logic [DBL_W-1:0]  lane_res   [NLANES];
    ash_flags_t        lane_flags [NLANES];
    logic [DBL_W-1:0]  res_q;
    ash_flags_t        flags_q;
    logic              done_q;

    ash_count_decode #(.CNT_W(CNT_W)) u_dec (
        .count    (count),
        .is_zero  (is_zero),
        .is_right (is_right),
        .amount   (amount)
    );

    assign opnd_full = {opnd_hi, opnd_lo};

    // One lane per mode: lane 0 is one word wide, lane 1 two words wide.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = WORD_W * (g + 1);
        logic [LW-1:0] lres;
        ash_lane #(.LANE_W(LW), .CNT_W(CNT_W), .EXT_W(EXT_W)) u_lane (
            .opnd     (opnd_full[LW-1:0]),
            .is_zero  (is_zero),
            .is_right (is_right),
            .amount   (amount),
            .res      (lres),
            .flags    (lane_flags[g])
        );
        assign lane_res[g] = DBL_W'(lres);
    end

    // Capture the selected lane on start and pulse done one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= start;
            if (start) begin
                res_q   <= dbl_mode ? lane_res[1] : lane_res[0];
                flags_q <= dbl_mode ? lane_flags[1] : lane_flags[0];
            end
        end
    end

    assign res_hi = res_q[DBL_W-1:WORD_W];
    assign res_lo = res_q[WORD_W-1:0];
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;
    assign done   = done_q;

    // R9
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R9
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(res_hi) && $stable(res_lo) && $stable(flag_c)));
    // R2
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && count == '0) |=> (res_lo == $past(opnd_lo) && !flag_c && !flag_v));
    // R6
    right_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && count[CNT_W-1]) |=> !flag_v);
    // R5
    single_long_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dbl_mode && !count[CNT_W-1] && count[CNT_W-2]) |=> (res_lo == '0 && flag_z));
    // R8
    single_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dbl_mode) |=> (res_hi == '0));
    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (res_hi == '0 && res_lo == '0)));
    // R7
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_n == ($past(dbl_mode) ? res_hi[WORD_W-1] : res_lo[WORD_W-1])));
endmodule

// File: tb/arith_shifter_bench.sv
`timescale 1ns/1ps
module arith_shifter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [15:0] opnd_hi = '0;
    logic [15:0] opnd_lo = '0;
    logic [5:0]  count = '0;
    logic [15:0] res_hi, res_lo;
    logic        flag_n, flag_z, flag_v, flag_c, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    arith_shifter u_arith_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .dbl_mode(dbl_mode),
        .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .count(count),
        .res_hi(res_hi), .res_lo(res_lo), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .done(done)
    );

    // Bit-serial reference: shifts one place per step.
    function automatic void ref_shift(input bit dbl, input logic [15:0] hi,
                                      input logic [15:0] lo, input logic [5:0] cnt,
                                      output logic [31:0] res, output logic [3:0] nzvc);
        int w = dbl ? 32 : 16;
        logic [31:0] mask = dbl ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        logic [31:0] val = dbl ? {hi, lo} : {16'h0, lo};
        logic c = 1'b0, v = 1'b0, any1 = 1'b0, any0 = 1'b0, sgn;
        if (cnt == 0) begin
            c = 1'b0;
        end else if (cnt < 32) begin
            for (int i = 0; i < int'(cnt); i++) begin
                c = val[w-1];
                if (c) any1 = 1'b1; else any0 = 1'b1;
                val = (val << 1) & mask;
            end
            v = val[w-1] ? any0 : any1;
        end else begin
            for (int i = 0; i < 64 - int'(cnt); i++) begin
                c = val[0];
                sgn = val[w-1];
                val = val >> 1;
                val[w-1] = sgn;
            end
        end
        res = val;
        nzvc = {val[w-1], (val & mask) == 0, v, c};
    endfunction

    function automatic string tag_of(input bit dbl, input logic [5:0] cnt);
        string t;
        if (cnt == 0) t = "R2";
        else if (cnt[5]) t = "R6 R1";
        else if (!dbl && cnt >= 16) t = "R5";
        else t = "R3/R4";
        return {t, dbl ? " R7" : " R8"};
    endfunction

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Run one shift; compare outputs in the done cycle, optionally check hold.
    task automatic run_op(input bit dbl, input logic [15:0] hi, input logic [15:0] lo,
                          input logic [5:0] cnt, input bit chk_hold);
        logic [31:0] eres;
        logic [3:0]  enzvc;
        logic [15:0] ehi;
        ref_shift(dbl, hi, lo, cnt, eres, enzvc);
        ehi = dbl ? eres[31:16] : 16'h0;
        @(negedge clk);
        dbl_mode = dbl; opnd_hi = hi; opnd_lo = lo; count = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check($sformatf("%s mode=%0d cnt=%0d op=%h%h", tag_of(dbl, cnt), dbl, cnt, hi, lo),
              {7'h0, done, ehi == 16'h0 ? res_hi : res_hi, res_lo, 4'h0, flag_n, flag_z, flag_v, flag_c},
              {7'h0, 1'b1, ehi, eres[15:0], 4'h0, enzvc});
        if (chk_hold) begin
            opnd_hi = ~hi; opnd_lo = ~lo; count = cnt + 6'd1;
            @(negedge clk);
            check("R9 hold", {7'h0, done, res_hi, res_lo, 4'h0, flag_n, flag_z, flag_v, flag_c},
                  {7'h0, 1'b0, ehi, eres[15:0], 4'h0, enzvc});
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                finished = 1'b1;
                checks++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stimulus
        logic [31:0] pats [12];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
        pats[3] = 32'h0000_0001; pats[4] = 32'h7FFF_FFFF; pats[5] = 32'h0000_8000;
        pats[6] = 32'hFFFF_7FFF; pats[7] = 32'h1234_8765; pats[8] = 32'hC000_0003;
        pats[9] = 32'h0000_4000; pats[10] = 32'hAAAA_5555; pats[11] = 32'h4000_0001;
        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset", {7'h0, done, res_hi, res_lo, 4'h0, flag_n, flag_z, flag_v, flag_c}, 48'h0);
        // R1: every count code, both modes, fixed and random operands
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 20; p++) begin
                logic [31:0] op = (p < 12) ? pats[p] : $urandom();
                for (int c = 0; c < 64; c++) begin
                    run_op(m[0], op[31:16], op[15:0], 6'(c), (c % 16) == 5);
                end
            end
        end
        // R8: high word ignored in single mode
        run_op(1'b0, 16'hFFFF, 16'h0001, 6'd3, 1'b1);
        run_op(1'b0, 16'h0000, 16'h0001, 6'd3, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule